// File: doc/BRIEF.md
# Sequential Integer Divider

This block divides either a 32-bit or a 16-bit dividend by a 16-bit divisor, in signed or unsigned two's-complement arithmetic. It returns a 16-bit quotient and a 16-bit remainder on separate outputs. The block retires one quotient bit per clock, so it takes 16 iterations whatever the dividend width. One conditioning cycle before the iterations and one fix-up cycle after them give a fixed latency that is the same for all four operation forms. The operands are presented on plain inputs. Choosing them from a register file and decoding the operation are left to the surrounding logic.

A one-cycle `start` is accepted only while the block is idle. At that edge the operands are captured into internal registers, so the inputs may change freely afterwards.

The controller has four states:
- **ST_IDLE** waits for `start`.
- **ST_PREP** forms the 32-bit dividend, takes the magnitudes of both operands, records the result signs, and pre-checks divide-by-zero and the unsigned quotient range.
- **ST_ITER** runs 16 restoring shift-subtract steps.
- **ST_FIN** restores the signs, applies the final range check and publishes the results.

The transitions are:
- ST_IDLE→ST_PREP on an accepted start.
- ST_PREP→ST_ITER unconditionally.
- ST_ITER→ST_ITER while the step counter is below 15.
- ST_ITER→ST_FIN on the sixteenth step.
- ST_FIN→ST_IDLE unconditionally, with `done` pulsed.

A zero divisor and a quotient that cannot be represented are both flagged. Neither shortens the sequence.

Top module: `idiv_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `done`, `div_zero` and `ovf` are 0 and `quot` and `rem` are 0 until the first operation completes.
- R2: `start` is accepted when it is high at a rising edge while `busy` is low. `done` is then high only in the cycle that follows the 18th rising edge after the accepting edge. It stays high for exactly one cycle. The latency is the same for `wide`=0 and `wide`=1, and for both values of `signed_mode`.
- R3: `busy` is high from the cycle after the accepting edge until `done` rises, and it is low in the `done` cycle. A `start` that arrives while `busy` is high is ignored: the running operation and its operands are unchanged.
- R4: With `signed_mode`=0 and `wide`=1, the dividend is the unsigned value {`dvd_hi`,`dvd_lo`}, with `dvd_hi` as bits 31..16. The outputs are `quot` = floor(dividend/divisor) and `rem` = dividend − quot·divisor.
- R5: With `signed_mode`=1 the operands are two's complement. `quot` is the quotient truncated toward zero. `rem` has the sign of the dividend, is smaller in magnitude than the divisor, and satisfies dividend = quot·divisor + rem.
- R6: With `wide`=0 only `dvd_lo` is used and `dvd_hi` has no effect. `dvd_lo` is sign-extended when `signed_mode`=1 and zero-extended when `signed_mode`=0.
- R7: A zero divisor sets `div_zero`=1 and `ovf`=0, forces `quot` and `rem` to 0, and completes with the latency of R2.
- R8: When the divisor is non-zero but the true quotient lies outside 0..65535 (unsigned) or −32768..32767 (signed), the block sets `ovf`=1 and `div_zero`=0 and forces `quot` and `rem` to 0.
- R9: `quot`, `rem`, `div_zero` and `ovf` change only at the edge that raises `done`. They hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a division |
| wide | input | 1 | 1: 32-bit dividend {dvd_hi,dvd_lo}; 0: 16-bit dividend dvd_lo |
| signed_mode | input | 1 | 1: two's-complement operands; 0: unsigned |
| dvd_hi | input | 16 | Upper dividend word (used only when wide=1) |
| dvd_lo | input | 16 | Lower dividend word |
| dvsr | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | 16 | Quotient |
| rem | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient not representable in 16 bits |

## Verification
The bench targets the sign corners:
- **−32768/−1 in the 16-bit signed form.** A design that never range-checks the magnitude returns 0x8000 with no flag.
- **Mixed-sign divisions.** A design that floors instead of truncating gives a quotient one too negative and a remainder with the divisor's sign.
- **Narrow forms with a non-zero upper word.** A design that does not mask that word produces a huge quotient or a false overflow.
- **An unsigned narrow dividend with bit 15 set.** Wrong extension turns it negative.

The remaining cases are:
- **The unsigned 32-bit range limit, where the upper word equals the divisor.** A missing pre-check here yields a wrapped quotient.
- **A zero divisor.** This must neither hang nor finish early.
- **A second `start` issued mid-operation.** A design that restarts or re-captures the operands returns the intruder's result or a late `done`.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ITER = 2'd2,
        ST_FIN  = 2'd3
    } idiv_state_e;

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: dividend extension, magnitudes, result signs
// and the range pre-check that keeps 16 steps sufficient.
module idiv_prep #(
    parameter int W = 16
) (
    input  logic           wide,
    input  logic           sgn,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   dvsr,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dvsr_mag,
    output logic           neg_q,
    output logic           neg_r,
    output logic           dz,
    output logic           pre_ovf
);
    localparam logic [2*W-1:0] ONE_D = {{(2*W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0]   ONE_S = {{(W-1){1'b0}}, 1'b1};

    logic [2*W-1:0] dvd_full;
    logic           dvd_neg;
    logic           dvsr_neg;

    always_comb begin
        if (wide) begin
            dvd_full = {hi, lo};
        end else begin
            dvd_full = {{W{sgn & lo[W-1]}}, lo};
        end
        dvd_neg  = sgn & dvd_full[2*W-1];
        dvsr_neg = sgn & dvsr[W-1];
        dvd_mag  = dvd_neg  ? ((~dvd_full) + ONE_D) : dvd_full;
        dvsr_mag = dvsr_neg ? ((~dvsr) + ONE_S)     : dvsr;
        neg_q    = dvd_neg ^ dvsr_neg;
        neg_r    = dvd_neg;
        dz       = (dvsr == '0);
        // quotient magnitude needs more than W bits when upper half >= divisor
        pre_ovf  = !dz && (dvd_mag[2*W-1:W] >= dvsr_mag);
    end

endmodule

// File: rtl/idiv_step.sv
// One restoring shift-subtract step: retires one quotient bit.
module idiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] dvsr_mag,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] q_out
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       take;

    always_comb begin
        trial   = {rem_in, q_in[W-1]};
        diff    = trial - {1'b0, dvsr_mag};
        take    = (trial >= {1'b0, dvsr_mag});
        rem_out = take ? diff[W-1:0] : trial[W-1:0];
        q_out   = {q_in[W-2:0], take};
    end

endmodule

// File: rtl/idiv_post.sv
// Sign restoration, final signed range check and result forcing.
module idiv_post #(
    parameter int W = 16
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         sgn,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         dz,
    input  logic         pre_ovf,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         dz_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] ONE_S = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] HALF  = {1'b1, {(W-1){1'b0}}};

    logic rng_ovf;
    logic kill;

    always_comb begin
        if (sgn) begin
            rng_ovf = neg_q ? (q_mag > HALF) : (q_mag >= HALF);
        end else begin
            rng_ovf = 1'b0;
        end
        ovf_o = !dz && (pre_ovf || rng_ovf);
        dz_o  = dz;
        kill  = dz || ovf_o;
        if (kill) begin
            quot = '0;
            rem  = '0;
        end else begin
            quot = neg_q ? ((~q_mag) + ONE_S) : q_mag;
            rem  = neg_r ? ((~r_mag) + ONE_S) : r_mag;
        end
    end

endmodule

// File: rtl/idiv_seq.sv
module idiv_seq
    import idiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         wide,
    input  logic         signed_mode,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvsr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         div_zero,
    output logic         ovf
);
    localparam int            CW    = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST  = CW'(W - 1);
    localparam logic [CW-1:0] INC   = CW'(1);

    idiv_state_e state, nxt;

    // captured operands
    logic         c_wide, c_sgn;
    logic [W-1:0] c_hi, c_lo, c_dvsr;
    // iteration state
    logic [W-1:0]  r_rem, r_q, r_d;
    logic          r_negq, r_negr, r_dz, r_pov;
    logic [CW-1:0] cnt;

    // conditioning outputs
    logic [2*W-1:0] p_mag;
    logic [W-1:0]   p_dmag;
    logic           p_negq, p_negr, p_dz, p_pov;
    // step outputs
    logic [W-1:0]   s_rem, s_q;
    // post outputs
    logic [W-1:0]   o_quot, o_rem;
    logic           o_dz, o_ovf;

    idiv_prep #(.W(W)) prep_i (
        .wide     (c_wide),
        .sgn      (c_sgn),
        .hi       (c_hi),
        .lo       (c_lo),
        .dvsr     (c_dvsr),
        .dvd_mag  (p_mag),
        .dvsr_mag (p_dmag),
        .neg_q    (p_negq),
        .neg_r    (p_negr),
        .dz       (p_dz),
        .pre_ovf  (p_pov)
    );

    idiv_step #(.W(W)) step_i (
        .rem_in   (r_rem),
        .q_in     (r_q),
        .dvsr_mag (r_d),
        .rem_out  (s_rem),
        .q_out    (s_q)
    );

    idiv_post #(.W(W)) post_i (
        .q_mag   (r_q),
        .r_mag   (r_rem),
        .sgn     (c_sgn),
        .neg_q   (r_negq),
        .neg_r   (r_negr),
        .dz      (r_dz),
        .pre_ovf (r_pov),
        .quot    (o_quot),
        .rem     (o_rem),
        .dz_o    (o_dz),
        .ovf_o   (o_ovf)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_PREP;
            ST_PREP: nxt = ST_ITER;
            ST_ITER: if (cnt == LAST) nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign busy = (state != ST_IDLE);

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_wide   <= 1'b0;
            c_sgn    <= 1'b0;
            c_hi     <= '0;
            c_lo     <= '0;
            c_dvsr   <= '0;
            r_rem    <= '0;
            r_q      <= '0;
            r_d      <= '0;
            r_negq   <= 1'b0;
            r_negr   <= 1'b0;
            r_dz     <= 1'b0;
            r_pov    <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            quot     <= '0;
            rem      <= '0;
            div_zero <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        c_wide <= wide;
                        c_sgn  <= signed_mode;
                        c_hi   <= dvd_hi;
                        c_lo   <= dvd_lo;
                        c_dvsr <= dvsr;
                    end
                end
                ST_PREP: begin
                    r_rem  <= p_mag[2*W-1:W];
                    r_q    <= p_mag[W-1:0];
                    r_d    <= p_dmag;
                    r_negq <= p_negq;
                    r_negr <= p_negr;
                    r_dz   <= p_dz;
                    r_pov  <= p_pov;
                    cnt    <= '0;
                end
                ST_ITER: begin
                    r_rem <= s_rem;
                    r_q   <= s_q;
                    cnt   <= cnt + INC;
                end
                ST_FIN: begin
                    quot     <= o_quot;
                    rem      <= o_rem;
                    div_zero <= o_dz;
                    ovf      <= o_ovf;
                    done     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/idiv_seq_chk.sv
module idiv_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quot,
    input logic [W-1:0] rem,
    input logic         div_zero,
    input logic         ovf
);
    localparam int         LAT = W + 2;
    localparam int         BW  = $clog2(LAT + 2) + 1;
    localparam logic [BW-1:0] LAT_V = BW'(LAT);
    localparam logic [BW-1:0] ONE_B = BW'(1);

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (busy) begin
            bcnt <= bcnt + ONE_B;
        end else begin
            bcnt <= '0;
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == LAT_V));

    // R3
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (quot == '0 && rem == '0 && !ovf));

    // R8
    ovf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (quot == '0 && rem == '0 && !div_zero));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quot) && $stable(rem) && $stable(div_zero) && $stable(ovf)));

endmodule

bind idiv_seq idiv_seq_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .quot     (quot),
    .rem      (rem),
    .div_zero (div_zero),
    .ovf      (ovf)
);

// File: tb/idiv_seq_tb_top.sv
`timescale 1ns/1ps
module idiv_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] dvd_hi = '0;
    logic [15:0] dvd_lo = '0;
    logic [15:0] dvsr = '0;
    logic        busy, done, div_zero, ovf;
    logic [15:0] quot, rem;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    idiv_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wide        (wide),
        .signed_mode (signed_mode),
        .dvd_hi      (dvd_hi),
        .dvd_lo      (dvd_lo),
        .dvsr        (dvsr),
        .busy        (busy),
        .done        (done),
        .quot        (quot),
        .rem         (rem),
        .div_zero    (div_zero),
        .ovf         (ovf)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // reference arithmetic from the requirements
    task automatic model(input bit w, input bit s, input logic [15:0] hi, input logic [15:0] lo,
                         input logic [15:0] d, output logic [15:0] eq, output logic [15:0] er,
                         output bit ez, output bit eo);
        longint a, b, qq, rr;
        if (w) a = s ? longint'($signed({hi, lo})) : longint'({hi, lo});
        else   a = s ? longint'($signed(lo))       : longint'(lo);
        b = s ? longint'($signed(d)) : longint'(d);
        ez = 1'b0; eo = 1'b0; eq = '0; er = '0;
        if (b == 0) begin
            ez = 1'b1;
        end else begin
            qq = a / b;
            rr = a % b;
            eo = s ? (qq > 32767 || qq < -32768) : (qq > 65535);
            if (!eo) begin
                eq = qq[15:0];
                er = rr[15:0];
            end
        end
    endtask

    // one division with timing and result checks; optional intruding start
    task automatic run_op(input bit w, input bit s, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] d, input bit poke, input string tag);
        logic [15:0] eq, er;
        bit ez, eo;
        model(w, s, hi, lo, d, eq, er, ez, eo);
        @(negedge clk);
        wide = w; signed_mode = s; dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, {tag, " R3 busy after accept"}, 32'(busy), 32'd1);
        for (int i = 1; i <= 17; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(done === 1'b0 && busy === 1'b1, {tag, " R2 early done / R3 busy"},
                {30'd0, busy, done}, 32'd2);
            if (poke && i == 5) begin
                start = 1'b1; wide = ~w; signed_mode = ~s; dvd_hi = 16'h7FFF;
                dvd_lo = 16'h1234; dvsr = 16'h0003;
            end
            if (poke && i == 6) start = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b1, {tag, " R2 done at latency"}, 32'(done), 32'd1);
        chk(busy === 1'b0, {tag, " R3 busy low with done"}, 32'(busy), 32'd0);
        chk(quot === eq, {tag, " quot R4 R5 R6"}, 32'(quot), 32'(eq));
        chk(rem === er, {tag, " rem R4 R5 R6"}, 32'(rem), 32'(er));
        chk(div_zero === ez, {tag, " R7 div_zero"}, 32'(div_zero), 32'(ez));
        chk(ovf === eo, {tag, " R8 ovf"}, 32'(ovf), 32'(eo));
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R2 done one cycle"}, 32'(done), 32'd0);
        chk(quot === eq && rem === er, {tag, " R9 hold"}, {quot, rem}, {eq, er});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset handshake", {30'd0, busy, done}, 32'd0);
        chk(quot === 16'd0 && rem === 16'd0, "R1 reset results", {quot, rem}, 32'd0);
        chk(div_zero === 1'b0 && ovf === 1'b0, "R1 reset flags", {30'd0, div_zero, ovf}, 32'd0);
    endtask

    task automatic t_unsigned_wide();
        run_op(1, 0, 16'h0001, 16'h0000, 16'd3, 0, "R4 65536/3");
        run_op(1, 0, 16'h1234, 16'h5678, 16'hFFFF, 0, "R4 big/ffff");
        run_op(1, 0, 16'h0000, 16'h0007, 16'd9, 0, "R4 small");
        run_op(1, 0, 16'h7FFE, 16'hFFFF, 16'h7FFF, 0, "R4 max quot");
    endtask

    task automatic t_signed();
        run_op(1, 1, 16'hFFFF, 16'hFFF9, 16'd2, 0, "R5 -7/2");
        run_op(1, 1, 16'h0000, 16'h0007, 16'hFFFE, 0, "R5 7/-2");
        run_op(1, 1, 16'hFFFF, 16'hFFF9, 16'hFFFE, 0, "R5 -7/-2");
        run_op(1, 1, 16'hFFC0, 16'h0000, 16'h0080, 0, "R5 -32768 exact");
        run_op(0, 1, 16'h0000, 16'h8000, 16'h0003, 0, "R5 narrow min/3");
    endtask

    task automatic t_narrow();
        run_op(0, 0, 16'hFFFF, 16'hFFFF, 16'd10, 0, "R6 unsigned ext");
        run_op(0, 1, 16'h5A5A, 16'hFF9C, 16'd7, 0, "R6 signed ext");
        run_op(0, 0, 16'h8000, 16'h0064, 16'd7, 0, "R6 hi ignored");
    endtask

    task automatic t_zero();
        run_op(1, 0, 16'h0001, 16'h2345, 16'd0, 0, "R7 unsigned zero");
        run_op(0, 1, 16'h0000, 16'hFFFF, 16'd0, 0, "R7 signed zero");
    endtask

    task automatic t_overflow();
        run_op(1, 0, 16'h0005, 16'h0000, 16'd5, 0, "R8 hi equals divisor");
        run_op(0, 1, 16'h0000, 16'h8000, 16'hFFFF, 0, "R8 -32768/-1");
        run_op(1, 1, 16'h0001, 16'h0000, 16'd2, 0, "R8 signed +32768");
        run_op(1, 1, 16'hFFFF, 16'h0000, 16'd2, 0, "R8 signed -32768 fits");
    endtask

    task automatic t_busy_start();
        run_op(1, 0, 16'h0002, 16'h0000, 16'd7, 1, "R3 start while busy");
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 40; k++) begin
            run_op(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                   (k % 8 == 0) ? 16'($urandom % 4) : 16'($urandom), 0, "R4 R5 sweep");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_unsigned_wide();
        t_signed();
        t_narrow();
        t_zero();
        t_overflow();
        t_busy_start();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule